// File: doc/BRIEF.md
# DMA Channel Register File with Interrupt Combiner

This block is the software-visible register file of a small multi-channel DMA controller. It sits on a 32-bit APB-style slave bus that decodes a 4 KB window. The bus has no wait states. For each channel it stores five words: the source address, the destination address, the next-descriptor link, the control word and the configuration word. All of these go to the transfer engine as flat vectors. The block also holds a global configuration word, whose bit 0 enables the controller, and a sync word.

The transfer engine reports back with single-cycle pulses. One kind of pulse sets terminal-count status, one sets error status, and one clears a channel's enable bit when the channel has finished. There are no separate mask registers. Each channel's configuration word carries its two interrupt enables: bit 15 for terminal count and bit 14 for error. The block drives three level interrupts: error, terminal count, and the OR of the two. The channel count is a parameter, normally 8 or 2. It changes the first identification byte, and it sets which channel slots respond to the bus.

Top module: `dmarf_regs`

## Requirements
- R1: After reset, all status bits, the global configuration, the sync word and every channel word read as zero, and all three interrupt outputs are low.
- R2: Channel n's words sit at 0x100 + 0x20·n: +0x00 source, +0x04 destination, +0x08 link, +0x0C control, +0x10 configuration. Each word reads back the last value written to it. Slot words +0x14 to +0x1C read as zero.
- R3: A bus access to a slot whose index is at or above NCH has no effect, and reading it returns zero.
- R4: A one-cycle pulse on bit n of `eng_tc_set` or `eng_err_set` sets raw status bit n. The bit stays set until it is cleared. Raw terminal-count status reads at 0x14 and raw error status at 0x18. Writes to these read-only offsets are ignored.
- R5: Writing 0x08 clears the raw terminal-count bits where the written data is 1. Writing 0x10 does the same for error status. An engine set pulse in the same cycle as the clear wins.
- R6: The masked terminal-count status is raw terminal-count AND configuration bit 15, and reads at 0x04. The masked error status is raw error AND configuration bit 14, and reads at 0x0C. Offset 0x00 reads the OR of the two.
- R7: `irq_tc` is high when any masked terminal-count bit is set. `irq_err` is high when any masked error bit is set. `irq_any` is their OR.
- R8: Offset 0x1C reads a bit per channel equal to configuration bit 0. A pulse on `eng_chan_off[n]` clears that bit, and it wins over a bus write to the same configuration word in the same cycle.
- R9: Offset 0x30 holds the global configuration, and its bit 0 drives `ctrl_en`. Offset 0x34 holds the sync word, and it drives `sync_out`. Offsets 0x20 to 0x2C read as zero and ignore writes.
- R10: Word k (k = 0..7) at 0xFE0 + 4·k reads identification byte k in bits 7:0. The bytes are 0x80 (NCH = 8) or 0x81 (any other NCH), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Each channel's stored words appear on `chan_src`, `chan_dst`, `chan_link`, `chan_ctrl` and `chan_cfg`, with channel n in bits 32·n+31 to 32·n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational on `paddr` |
| eng_tc_set | input | NCH | Terminal-count set pulses from the engine |
| eng_err_set | input | NCH | Error set pulses from the engine |
| eng_chan_off | input | NCH | Channel-enable clear pulses from the engine |
| ctrl_en | output | 1 | Controller enable (global configuration bit 0) |
| sync_out | output | 32 | Sync word |
| chan_src | output | 32·NCH | Source address of every channel |
| chan_dst | output | 32·NCH | Destination address of every channel |
| chan_link | output | 32·NCH | Next-descriptor link of every channel |
| chan_ctrl | output | 32·NCH | Control word of every channel |
| chan_cfg | output | 32·NCH | Configuration word of every channel |
| irq_err | output | 1 | Error interrupt |
| irq_tc | output | 1 | Terminal-count interrupt |
| irq_any | output | 1 | OR of both interrupts |

## Verification
A bus write or an engine pulse changes stored state at one rising edge. The effect is visible at `prdata`, at the exported vectors and at the interrupt pins straight after that edge, because those outputs are combinational from the registers. Bus reads need no edge at all. The bench therefore drives every stimulus at a falling edge and releases it at the next falling edge. It reads by placing the address at a falling edge and sampling a nanosecond later, so each check falls half a cycle after the edge that made its result. The same-cycle priority cases put the engine pulse in the bus access phase itself, so both updates meet at the same edge.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    // configuration-word bit positions used by the interrupt logic
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_ERRMSK_BIT = 14;
    localparam int CFG_TCMSK_BIT  = 15;

    // global word indices (byte offset / 4)
    localparam logic [5:0] GW_ANY      = 6'd0;
    localparam logic [5:0] GW_TC_MSK   = 6'd1;
    localparam logic [5:0] GW_TC_CLR   = 6'd2;
    localparam logic [5:0] GW_ERR_MSK  = 6'd3;
    localparam logic [5:0] GW_ERR_CLR  = 6'd4;
    localparam logic [5:0] GW_TC_RAW   = 6'd5;
    localparam logic [5:0] GW_ERR_RAW  = 6'd6;
    localparam logic [5:0] GW_EN_SUM   = 6'd7;
    localparam logic [5:0] GW_GCFG     = 6'd12;
    localparam logic [5:0] GW_SYNC     = 6'd13;

    typedef enum logic [2:0] {
        CW_SRC  = 3'd0,
        CW_DST  = 3'd1,
        CW_LINK = 3'd2,
        CW_CTRL = 3'd3,
        CW_CFG  = 3'd4
    } chan_word_e;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] cfg;
    } chan_regs_t;

    typedef struct packed {
        logic [WORD_W-1:0] gcfg;
        logic [WORD_W-1:0] sync;
    } glob_regs_t;

    function automatic logic [7:0] id_byte(input logic [2:0] k, input int nch);
        case (k)
            3'd0:    return (nch == 8) ? 8'h80 : 8'h81;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h0A;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dmarf_chan.sv
module dmarf_chan
    import dmarf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  chan_word_e        wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              chan_off,
    output chan_regs_t        regs_q
);

    chan_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_word)
                CW_SRC:  regs_d.src  = wr_data;
                CW_DST:  regs_d.dst  = wr_data;
                CW_LINK: regs_d.link = wr_data;
                CW_CTRL: regs_d.ctrl = wr_data;
                CW_CFG:  regs_d.cfg  = wr_data;
                default: ;
            endcase
        end
        // engine completion beats a bus write in the same cycle
        if (chan_off) begin
            regs_d.cfg[CFG_EN_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/dmarf_irq.sv
module dmarf_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    input  logic           tc_clr_en,
    input  logic           err_clr_en,
    input  logic [NCH-1:0] clr_bits,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] tc_raw,
    output logic [NCH-1:0] err_raw,
    output logic [NCH-1:0] tc_masked,
    output logic [NCH-1:0] err_masked,
    output logic           irq_tc,
    output logic           irq_err,
    output logic           irq_any
);

    typedef struct packed {
        logic [NCH-1:0] tc;
        logic [NCH-1:0] err;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d     = stat_q;
        stat_d.tc  = (stat_q.tc  & ~(tc_clr_en  ? clr_bits : '0)) | tc_set;
        stat_d.err = (stat_q.err & ~(err_clr_en ? clr_bits : '0)) | err_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign tc_raw     = stat_q.tc;
    assign err_raw    = stat_q.err;
    assign tc_masked  = stat_q.tc  & tc_mask;
    assign err_masked = stat_q.err & err_mask;
    assign irq_tc     = |tc_masked;
    assign irq_err    = |err_masked;
    assign irq_any    = |(tc_masked | err_masked);

endmodule

// File: rtl/dmarf_regs.sv
module dmarf_regs
    import dmarf_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [ADDR_W-1:0]     paddr,
    input  logic [WORD_W-1:0]     pwdata,
    output logic [WORD_W-1:0]     prdata,
    input  logic [NCH-1:0]        eng_tc_set,
    input  logic [NCH-1:0]        eng_err_set,
    input  logic [NCH-1:0]        eng_chan_off,
    output logic                  ctrl_en,
    output logic [WORD_W-1:0]     sync_out,
    output logic [NCH*WORD_W-1:0] chan_src,
    output logic [NCH*WORD_W-1:0] chan_dst,
    output logic [NCH*WORD_W-1:0] chan_link,
    output logic [NCH*WORD_W-1:0] chan_ctrl,
    output logic [NCH*WORD_W-1:0] chan_cfg,
    output logic                  irq_err,
    output logic                  irq_tc,
    output logic                  irq_any
);

    localparam int SLOT_W = 3;   // slot index field paddr[7:5]

    // ---------------- decode ----------------
    logic              bus_wr;
    logic              in_chan, in_glob, in_id;
    logic [SLOT_W-1:0] ch_idx;
    chan_word_e        ch_word;
    logic [5:0]        g_word;
    logic [2:0]        id_idx;
    logic              addr_unused;

    assign bus_wr      = psel & penable & pwrite;
    assign in_chan     = (paddr[11:8] == 4'h1);
    assign in_glob     = (paddr[11:8] == 4'h0);
    assign in_id       = (paddr[11:5] == 7'h7F);
    assign ch_idx      = paddr[7:5];
    assign ch_word     = chan_word_e'(paddr[4:2]);
    assign g_word      = paddr[7:2];
    assign id_idx      = paddr[4:2];
    assign addr_unused = ^paddr[1:0];

    // ---------------- channels ----------------
    chan_regs_t     regs [NCH];
    logic [NCH-1:0] tc_mask, err_mask, en_sum;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dmarf_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && in_chan && (ch_idx == SLOT_W'(g))),
            .wr_word  (ch_word),
            .wr_data  (pwdata),
            .chan_off (eng_chan_off[g]),
            .regs_q   (regs[g])
        );
        assign tc_mask[g]                   = regs[g].cfg[CFG_TCMSK_BIT];
        assign err_mask[g]                  = regs[g].cfg[CFG_ERRMSK_BIT];
        assign en_sum[g]                    = regs[g].cfg[CFG_EN_BIT];
        assign chan_src [g*WORD_W +: WORD_W] = regs[g].src;
        assign chan_dst [g*WORD_W +: WORD_W] = regs[g].dst;
        assign chan_link[g*WORD_W +: WORD_W] = regs[g].link;
        assign chan_ctrl[g*WORD_W +: WORD_W] = regs[g].ctrl;
        assign chan_cfg [g*WORD_W +: WORD_W] = regs[g].cfg;
    end

    // ---------------- status and interrupts ----------------
    logic [NCH-1:0] tc_raw, err_raw, tc_masked, err_masked;

    dmarf_irq #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc_set     (eng_tc_set),
        .err_set    (eng_err_set),
        .tc_clr_en  (bus_wr && in_glob && (g_word == GW_TC_CLR)),
        .err_clr_en (bus_wr && in_glob && (g_word == GW_ERR_CLR)),
        .clr_bits   (pwdata[NCH-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .irq_tc     (irq_tc),
        .irq_err    (irq_err),
        .irq_any    (irq_any)
    );

    // ---------------- global words ----------------
    glob_regs_t glob_d, glob_q;

    always_comb begin
        glob_d = glob_q;
        if (bus_wr && in_glob) begin
            if (g_word == GW_GCFG) glob_d.gcfg = pwdata;
            if (g_word == GW_SYNC) glob_d.sync = pwdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q <= '0;
        end else begin
            glob_q <= glob_d;
        end
    end

    assign ctrl_en  = glob_q.gcfg[0];
    assign sync_out = glob_q.sync;

    // ---------------- read mux ----------------
    function automatic logic [WORD_W-1:0] zext(input logic [NCH-1:0] v);
        logic [WORD_W-1:0] r;
        r = '0;
        r[NCH-1:0] = v;
        return r;
    endfunction

    always_comb begin
        prdata = '0;
        if (in_id) begin
            prdata = {24'h0, id_byte(id_idx, NCH)};
        end else if (in_chan) begin
            for (int n = 0; n < NCH; n++) begin
                if (ch_idx == SLOT_W'(n)) begin
                    case (ch_word)
                        CW_SRC:  prdata = regs[n].src;
                        CW_DST:  prdata = regs[n].dst;
                        CW_LINK: prdata = regs[n].link;
                        CW_CTRL: prdata = regs[n].ctrl;
                        CW_CFG:  prdata = regs[n].cfg;
                        default: prdata = '0;
                    endcase
                end
            end
        end else if (in_glob) begin
            case (g_word)
                GW_ANY:     prdata = zext(tc_masked | err_masked);
                GW_TC_MSK:  prdata = zext(tc_masked);
                GW_ERR_MSK: prdata = zext(err_masked);
                GW_TC_RAW:  prdata = zext(tc_raw);
                GW_ERR_RAW: prdata = zext(err_raw);
                GW_EN_SUM:  prdata = zext(en_sum);
                GW_GCFG:    prdata = glob_q.gcfg;
                GW_SYNC:    prdata = glob_q.sync;
                default:    prdata = {{(WORD_W-1){1'b0}}, addr_unused & 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/dmarf_regs_chk.sv
module dmarf_regs_chk #(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [NCH-1:0]    eng_tc_set,
    input logic [NCH-1:0]    eng_err_set,
    input logic [NCH-1:0]    eng_chan_off,
    input logic [NCH-1:0]    tc_raw,
    input logic [NCH-1:0]    err_raw,
    input logic [NCH*32-1:0] chan_cfg,
    input logic              irq_tc,
    input logic              irq_err,
    input logic              irq_any
);

    logic [NCH-1:0] chk_tcm, chk_errm;
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            chk_tcm[n]  = chan_cfg[n*32 + 15];
            chk_errm[n] = chan_cfg[n*32 + 14];
        end
    end

    AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tc_set != '0) |=> ((tc_raw & $past(eng_tc_set)) == $past(eng_tc_set))); // R5

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_err_set != '0) |=> ((err_raw & $past(eng_err_set)) == $past(eng_err_set))); // R5

    AST_TC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(psel && penable && pwrite) && (eng_tc_set == '0)) |=> $stable(tc_raw)); // R4

    AST_IRQ_TC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tc == (|(tc_raw & chk_tcm))); // R7

    AST_IRQ_ERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == (|(err_raw & chk_errm))); // R7

    AST_IRQ_ANY_OR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_tc || irq_err)); // R7

    for (genvar g = 0; g < NCH; g++) begin : g_off
        AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            eng_chan_off[g] |=> !chan_cfg[g*32]); // R8
    end

endmodule

bind dmarf_regs dmarf_regs_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_dmarf_regs.sv
module test_dmarf_regs;

    localparam int NCH  = 2;
    localparam int WNCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, w_prdata;
    logic [NCH-1:0] eng_tc_set = '0, eng_err_set = '0, eng_chan_off = '0;
    logic        ctrl_en, irq_err, irq_tc, irq_any;
    logic [31:0] sync_out;
    logic [NCH*32-1:0] chan_src, chan_dst, chan_link, chan_ctrl, chan_cfg;
    logic        w_ctrl_en, w_irq_err, w_irq_tc, w_irq_any;
    logic [31:0] w_sync;
    logic [WNCH*32-1:0] w_src, w_dst, w_link, w_ctrl, w_cfg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dmarf_regs #(.NCH(NCH)) i_dmarf_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .eng_tc_set(eng_tc_set), .eng_err_set(eng_err_set), .eng_chan_off(eng_chan_off),
        .ctrl_en(ctrl_en), .sync_out(sync_out),
        .chan_src(chan_src), .chan_dst(chan_dst), .chan_link(chan_link),
        .chan_ctrl(chan_ctrl), .chan_cfg(chan_cfg),
        .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any)
    );

    dmarf_regs #(.NCH(WNCH)) i_dmarf_regs_wide (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(w_prdata),
        .eng_tc_set('0), .eng_err_set('0), .eng_chan_off('0),
        .ctrl_en(w_ctrl_en), .sync_out(w_sync),
        .chan_src(w_src), .chan_dst(w_dst), .chan_link(w_link),
        .chan_ctrl(w_ctrl), .chan_cfg(w_cfg),
        .irq_err(w_irq_err), .irq_tc(w_irq_tc), .irq_any(w_irq_any)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d,
                          input logic [NCH-1:0] tc = '0, input logic [NCH-1:0] er = '0,
                          input logic [NCH-1:0] off = '0);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1; eng_tc_set = tc; eng_err_set = er; eng_chan_off = off;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        eng_tc_set = '0; eng_err_set = '0; eng_chan_off = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] wd);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1;
        d = prdata; wd = w_prdata;
        psel = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] tc, input logic [NCH-1:0] er,
                         input logic [NCH-1:0] off);
        @(negedge clk);
        eng_tc_set = tc; eng_err_set = er; eng_chan_off = off;
        @(negedge clk);
        eng_tc_set = '0; eng_err_set = '0; eng_chan_off = '0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data or expected read
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h100, 32'h1111_0000, 4'd2},  // R2 ch0 src
        '{1'b1, 12'h104, 32'h0000_2222, 4'd2},  // R2 ch0 dst
        '{1'b1, 12'h108, 32'h0000_3333, 4'd2},  // R2 ch0 link
        '{1'b1, 12'h10C, 32'h0000_4444, 4'd2},  // R2 ch0 ctrl
        '{1'b1, 12'h110, 32'h0000_C001, 4'd2},  // R2 ch0 cfg: enable + both masks
        '{1'b1, 12'h120, 32'hAAAA_5555, 4'd2},  // R2 ch1 src
        '{1'b1, 12'h114, 32'hFFFF_FFFF, 4'd2},  // R2 unused slot word
        '{1'b0, 12'h100, 32'h1111_0000, 4'd2},  // R2
        '{1'b0, 12'h104, 32'h0000_2222, 4'd2},  // R2
        '{1'b0, 12'h108, 32'h0000_3333, 4'd2},  // R2
        '{1'b0, 12'h10C, 32'h0000_4444, 4'd2},  // R2
        '{1'b0, 12'h110, 32'h0000_C001, 4'd2},  // R2
        '{1'b0, 12'h114, 32'h0000_0000, 4'd2},  // R2 slot word 5 reads zero
        '{1'b0, 12'h120, 32'hAAAA_5555, 4'd2},  // R2
        '{1'b1, 12'h140, 32'h0000_DEAD, 4'd3},  // R3 slot 2 absent
        '{1'b0, 12'h140, 32'h0000_0000, 4'd3},  // R3
        '{1'b1, 12'h1E0, 32'h0000_1234, 4'd3},  // R3 slot 7 absent in 2-channel build
        '{1'b0, 12'h1E0, 32'h0000_0000, 4'd3},  // R3
        '{1'b0, 12'h100, 32'h1111_0000, 4'd3},  // R3 no aliasing onto slot 0
        '{1'b0, 12'h01C, 32'h0000_0001, 4'd8},  // R8 enabled summary
        '{1'b1, 12'h030, 32'h0000_0001, 4'd9},  // R9 global cfg
        '{1'b0, 12'h030, 32'h0000_0001, 4'd9},  // R9
        '{1'b1, 12'h034, 32'h0000_FFFF, 4'd9},  // R9 sync
        '{1'b0, 12'h034, 32'h0000_FFFF, 4'd9},  // R9
        '{1'b1, 12'h020, 32'h0000_0005, 4'd9},  // R9 reserved word
        '{1'b0, 12'h020, 32'h0000_0000, 4'd9},  // R9
        '{1'b0, 12'h028, 32'h0000_0000, 4'd9}   // R9
    };

    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, wrd;
        logic [7:0]  idb [8];
        idb = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(12'h110, rd, wrd); chk("R1", rd, 32'h0, "cfg after reset");
        bus_rd(12'h000, rd, wrd); chk("R1", rd, 32'h0, "status after reset");
        bus_rd(12'h030, rd, wrd); chk("R1", rd, 32'h0, "gcfg after reset");
        chk("R1", {29'h0, irq_err, irq_tc, irq_any}, 32'h0, "irqs after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_wr(VEC[i].addr, VEC[i].data);
            end else begin
                bus_rd(VEC[i].addr, rd, wrd);
                chk($sformatf("R%0d", VEC[i].req), rd, VEC[i].data,
                    $sformatf("read 0x%03h", VEC[i].addr));
            end
        end

        // R3 contrast: the 8-channel build does keep slot 7
        bus_rd(12'h1E0, rd, wrd); chk("R3", wrd, 32'h1234, "wide slot 7");

        // R10 identification bytes
        bus_rd(12'hFE0, rd, wrd); chk("R10", wrd, 32'h80, "wide id byte 0");
        for (int k = 0; k < 8; k++) begin
            bus_rd(12'hFE0 + 12'(4*k), rd, wrd);
            chk("R10", rd, {24'h0, idb[k]}, $sformatf("id byte %0d", k));
        end

        // R9 / R11 exported state
        chk("R9", {31'h0, ctrl_en}, 32'h1, "ctrl_en");
        chk("R9", sync_out, 32'h0000_FFFF, "sync_out");
        chk("R11", chan_src[63:32], 32'hAAAA_5555, "chan_src ch1");
        chk("R11", chan_ctrl[31:0], 32'h0000_4444, "chan_ctrl ch0");

        // R4 / R6 / R7 engine status
        pulse(2'b01, 2'b00, 2'b00);
        bus_rd(12'h014, rd, wrd); chk("R4", rd, 32'h1, "raw tc");
        bus_rd(12'h004, rd, wrd); chk("R6", rd, 32'h1, "masked tc");
        chk("R7", {29'h0, irq_err, irq_tc, irq_any}, 32'h3, "irq tc only");
        pulse(2'b10, 2'b10, 2'b00);
        bus_rd(12'h014, rd, wrd); chk("R4", rd, 32'h3, "raw tc both");
        bus_rd(12'h004, rd, wrd); chk("R6", rd, 32'h1, "ch1 tc unmasked");
        bus_rd(12'h018, rd, wrd); chk("R4", rd, 32'h2, "raw err");
        bus_rd(12'h00C, rd, wrd); chk("R6", rd, 32'h0, "ch1 err unmasked");
        chk("R7", {31'h0, irq_err}, 32'h0, "irq_err masked off");
        bus_wr(12'h130, 32'h0000_4000);
        bus_rd(12'h00C, rd, wrd); chk("R6", rd, 32'h2, "ch1 err masked in");
        bus_rd(12'h000, rd, wrd); chk("R6", rd, 32'h3, "combined status");
        chk("R7", {31'h0, irq_err}, 32'h1, "irq_err");

        // R5 write-one-to-clear and set priority
        bus_wr(12'h008, 32'h0000_0001);
        bus_rd(12'h014, rd, wrd); chk("R5", rd, 32'h2, "tc clear ch0");
        chk("R7", {30'h0, irq_tc, irq_any}, 32'h1, "irq_tc low after clear");
        bus_wr(12'h010, 32'h0000_0002, 2'b00, 2'b10, 2'b00);
        bus_rd(12'h018, rd, wrd); chk("R5", rd, 32'h2, "set beats clear");
        bus_wr(12'h010, 32'h0000_0002);
        bus_rd(12'h018, rd, wrd); chk("R5", rd, 32'h0, "err clear");
        chk("R7", {31'h0, irq_any}, 32'h0, "irq_any low");
        bus_wr(12'h014, 32'h0000_00FF);
        bus_rd(12'h014, rd, wrd); chk("R4", rd, 32'h2, "raw tc read-only");

        // R8 engine disable beats bus write
        bus_wr(12'h110, 32'h0000_C001, 2'b00, 2'b00, 2'b01);
        bus_rd(12'h110, rd, wrd); chk("R8", rd, 32'h0000_C000, "off beats write");
        bus_rd(12'h01C, rd, wrd); chk("R8", rd, 32'h0, "summary after off");
        chk("R11", chan_cfg[31:0], 32'h0000_C000, "chan_cfg ch0");

        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_rd(12'h120, rd, wrd); chk("R1", rd, 32'h0, "ch1 src after reset");
        bus_rd(12'h014, rd, wrd); chk("R1", rd, 32'h0, "raw tc after reset");
        chk("R1", {30'h0, ctrl_en, irq_any}, 32'h0, "ctrl_en/irq after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule